// File: doc/BRIEF.md
# Register Write Protection Unit

This unit guards writes to a small bank of peripheral registers. Each write request carries a word address, data and a privilege indicator. For each request the unit makes one of three decisions. It can apply the write by pulsing the target register's write strobe. It can drop the write silently. It can refuse the write and raise a bus error in the same cycle. The registers themselves live outside the unit. The unit only produces their strobes and keeps its own lock register.

The lock register holds four unlock bits, one per protected target: the compensation register, the control register, the status register and the lock register itself. A 1 means writes go through and a 0 means the target is locked. Locking works in one direction only. A write can clear lock bits but never set them again. Once the lock register's own bit is cleared, the whole lock register is frozen. Only a hardware reset or a software-reset pulse brings every bit back to unlocked.

A controlling state machine has two named states. In LK_OPEN the lock register accepts writes. In LK_SEALED it ignores them. It has three transitions:
- SEAL goes from LK_OPEN to LK_SEALED on an accepted lock write whose data bit 6 is 0.
- REOPEN goes from LK_SEALED to LK_OPEN on a software reset.
- HOLD keeps the current state in every other cycle.

A software reset in LK_OPEN also restores all lock bits.

Top module: `reg_write_guard`

## Requirements
- R1: After reset `lock_state` reads 4'b1111 (all unlocked) and the unit is in LK_OPEN.
- R2: A valid request with `req_priv`=0 while `cfg_user_ok`=0 raises `bus_err` in the same cycle. It produces no write strobe, and `lock_state` is unchanged in the next cycle.
- R3: Requests with `req_priv`=1, or with `cfg_user_ok`=1, never raise `bus_err`.
- R4: Word addresses 3, 4, 5 and 6 select the compensation, control, status and lock registers. Any other address pulses `we_open`. An accepted write to an unlocked target pulses its strobe (`we_comp`, `we_ctrl`, `we_stat`) in the request cycle. At most one strobe is high per cycle.
- R5: A write to a locked compensation, control or status register produces no strobe and no `bus_err`. Bits of `lock_state`: [0] compensation, [1] control, [2] status, [3] lock register.
- R6: An accepted write to the lock register while `lock_state[3]`=1 sets the next `lock_state` to the old value ANDed with `req_data[6:3]`. Data bit 3 maps to compensation, bit 4 to control, bit 5 to status and bit 6 to the lock register. A bit never returns from 0 to 1 through a write.
- R7: While `lock_state[3]`=0, writes to the lock register leave `lock_state` unchanged.
- R8: A write to the locked status register with `cfg_upd_mode`=1 and (`flag_invalid` or `flag_overflow`) set pulses `we_stat_tce` only. Otherwise `we_stat_tce` stays low. `we_stat` and `we_stat_tce` are never high together.
- R9: `soft_rst`=1 sets `lock_state` to 4'b1111 in the next cycle. This takes priority over a lock write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| soft_rst | input | 1 | Software reset pulse that restores all unlock bits |
| req_valid | input | 1 | Write request present |
| req_addr | input | ADDR_W | Word address of the write |
| req_data | input | DATA_W | Write data |
| req_priv | input | 1 | Request comes from privileged mode |
| cfg_user_ok | input | 1 | Unprivileged writes allowed |
| cfg_upd_mode | input | 1 | Limited status update while locked |
| flag_invalid | input | 1 | Time-invalid flag |
| flag_overflow | input | 1 | Time-overflow flag |
| we_comp | output | 1 | Compensation register write strobe |
| we_ctrl | output | 1 | Control register write strobe |
| we_stat | output | 1 | Full status register write strobe |
| we_stat_tce | output | 1 | Counter-enable-only status write strobe |
| we_open | output | 1 | Strobe for unprotected addresses |
| bus_err | output | 1 | Error response for a refused write |
| lock_state | output | 4 | Current unlock bits |

## Verification
A wrong lock bit or a wrong state shows up on the first later write to the affected target. That write either gets a strobe it should not get or loses one it should get. The error is also visible on `lock_state` one cycle after the faulty update. A bad error decision shows up in the request cycle itself, as `bus_err` together with the strobes. The bench compares all outputs every cycle against a model of the four unlock bits. Any divergence is therefore reported in the cycle it first becomes visible.

// File: rtl/reg_guard_pkg.sv
package reg_guard_pkg;
    localparam int ADDR_W     = 3;
    localparam int DATA_W     = 32;
    localparam int IDX_COMP   = 3;
    localparam int IDX_CTRL   = 4;
    localparam int IDX_STAT   = 5;
    localparam int IDX_LOCK   = 6;
    localparam int LOCK_LSB   = 3;
    localparam int NUM_LOCKS  = 4;

    typedef enum logic {
        LK_OPEN   = 1'b0,
        LK_SEALED = 1'b1
    } lk_state_t;
endpackage

// File: rtl/guard_decode.sv
module guard_decode
    import reg_guard_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int NL = NUM_LOCKS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [AW-1:0] req_addr,
    input  logic          req_priv,
    input  logic          cfg_user_ok,
    input  logic          cfg_upd_mode,
    input  logic          flag_invalid,
    input  logic          flag_overflow,
    input  logic [NL-1:0] lock_state,
    output logic          we_comp,
    output logic          we_ctrl,
    output logic          we_stat,
    output logic          we_stat_tce,
    output logic          we_open,
    output logic          lock_wr,
    output logic          bus_err
);
    logic accept;
    logic tce_ok;

    always_comb begin
        bus_err     = req_valid && !req_priv && !cfg_user_ok;
        accept      = req_valid && !bus_err;
        tce_ok      = cfg_upd_mode && (flag_invalid || flag_overflow);
        we_comp     = 1'b0;
        we_ctrl     = 1'b0;
        we_stat     = 1'b0;
        we_stat_tce = 1'b0;
        we_open     = 1'b0;
        lock_wr     = 1'b0;
        if (accept) begin
            unique case (req_addr)
                AW'(IDX_COMP): we_comp = lock_state[0];
                AW'(IDX_CTRL): we_ctrl = lock_state[1];
                AW'(IDX_STAT): begin
                    we_stat     = lock_state[2];
                    we_stat_tce = !lock_state[2] && tce_ok;
                end
                AW'(IDX_LOCK): lock_wr = lock_state[3];
                default:       we_open = 1'b1;
            endcase
        end
    end

    AST_ERR_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> !(we_comp || we_ctrl || we_stat || we_stat_tce || we_open || lock_wr)); // R2
    AST_PRIV_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (req_priv || cfg_user_ok) |-> !bus_err); // R3
    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({we_comp, we_ctrl, we_stat, we_stat_tce, we_open, lock_wr})); // R4
    AST_LOCKED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_priv && req_addr == AW'(IDX_CTRL) && !lock_state[1]) |-> (!we_ctrl && !bus_err)); // R5
    AST_TCE_ONLY_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        we_stat_tce |-> (!lock_state[2] && cfg_upd_mode && !we_stat)); // R8
endmodule

// File: rtl/guard_lock_fsm.sv
module guard_lock_fsm
    import reg_guard_pkg::*;
#(
    parameter int NL = NUM_LOCKS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          soft_rst,
    input  logic          lock_wr,
    input  logic [NL-1:0] wr_bits,
    output logic [NL-1:0] lock_state
);
    localparam int NR = NL - 1;

    lk_state_t      state_q, state_d;
    logic [NR-1:0]  reg_lk_q, reg_lk_d;

    always_comb begin
        state_d  = state_q;
        reg_lk_d = reg_lk_q;
        if (soft_rst) begin
            state_d  = LK_OPEN;
            reg_lk_d = '1;
        end else begin
            unique case (state_q)
                LK_OPEN: begin
                    if (lock_wr) begin
                        reg_lk_d = reg_lk_q & wr_bits[NR-1:0];
                        if (!wr_bits[NR]) state_d = LK_SEALED;
                    end
                end
                LK_SEALED: state_d = LK_SEALED;
                default:   state_d = LK_OPEN;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= LK_OPEN;
            reg_lk_q <= '1;
        end else begin
            state_q  <= state_d;
            reg_lk_q <= reg_lk_d;
        end
    end

    always_comb begin
        lock_state = {state_q == LK_OPEN, reg_lk_q};
    end

    AST_LOCK_MONOTONIC: assert property (@(posedge clk) disable iff (!rst_n)
        !soft_rst |=> ((lock_state & ~$past(lock_state)) == '0)); // R6
    AST_SEALED_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LK_SEALED && !soft_rst) |=> $stable(lock_state)); // R7
    AST_SOFT_REOPEN: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (lock_state == '1)); // R9
endmodule

// File: rtl/reg_write_guard.sv
module reg_write_guard
    import reg_guard_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 soft_rst,
    input  logic                 req_valid,
    input  logic [AW-1:0]        req_addr,
    input  logic [DW-1:0]        req_data,
    input  logic                 req_priv,
    input  logic                 cfg_user_ok,
    input  logic                 cfg_upd_mode,
    input  logic                 flag_invalid,
    input  logic                 flag_overflow,
    output logic                 we_comp,
    output logic                 we_ctrl,
    output logic                 we_stat,
    output logic                 we_stat_tce,
    output logic                 we_open,
    output logic                 bus_err,
    output logic [NUM_LOCKS-1:0] lock_state
);
    localparam int LMSB = LOCK_LSB + NUM_LOCKS - 1;

    logic lock_wr;
    logic unused_data;

    assign unused_data = ^{req_data[DW-1:LMSB+1], req_data[LOCK_LSB-1:0]};

    guard_decode #(.AW(AW), .NL(NUM_LOCKS)) u_dec (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_addr      (req_addr),
        .req_priv      (req_priv),
        .cfg_user_ok   (cfg_user_ok),
        .cfg_upd_mode  (cfg_upd_mode),
        .flag_invalid  (flag_invalid),
        .flag_overflow (flag_overflow),
        .lock_state    (lock_state),
        .we_comp       (we_comp),
        .we_ctrl       (we_ctrl),
        .we_stat       (we_stat),
        .we_stat_tce   (we_stat_tce),
        .we_open       (we_open),
        .lock_wr       (lock_wr),
        .bus_err       (bus_err)
    );

    guard_lock_fsm #(.NL(NUM_LOCKS)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_rst   (soft_rst),
        .lock_wr    (lock_wr),
        .wr_bits    (req_data[LMSB:LOCK_LSB]),
        .lock_state (lock_state)
    );

    AST_ERR_KEEPS_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_err && !soft_rst) |=> $stable(lock_state)); // R2
endmodule

// File: tb/tb_reg_write_guard.sv
module tb_reg_write_guard;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        soft_rst = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_addr = '0;
    logic [31:0] req_data = '0;
    logic        req_priv = 1'b0;
    logic        cfg_user_ok = 1'b0;
    logic        cfg_upd_mode = 1'b0;
    logic        flag_invalid = 1'b0;
    logic        flag_overflow = 1'b0;
    logic        we_comp, we_ctrl, we_stat, we_stat_tce, we_open, bus_err;
    logic [3:0]  lock_state;

    int checks = 0;
    int errors = 0;
    logic [3:0] mdl_lk;

    always #(CLK_PERIOD/2) clk = ~clk;

    reg_write_guard dut (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .req_valid(req_valid), .req_addr(req_addr), .req_data(req_data),
        .req_priv(req_priv), .cfg_user_ok(cfg_user_ok), .cfg_upd_mode(cfg_upd_mode),
        .flag_invalid(flag_invalid), .flag_overflow(flag_overflow),
        .we_comp(we_comp), .we_ctrl(we_ctrl), .we_stat(we_stat),
        .we_stat_tce(we_stat_tce), .we_open(we_open), .bus_err(bus_err),
        .lock_state(lock_state)
    );

    // Expected {we_comp, we_ctrl, we_stat, we_stat_tce, we_open, bus_err}
    function automatic logic [5:0] exp_out(input logic [3:0] lk);
        logic err, ok;
        err = req_valid && !req_priv && !cfg_user_ok;
        ok  = req_valid && !err;
        return {ok && req_addr == 3'd3 && lk[0],
                ok && req_addr == 3'd4 && lk[1],
                ok && req_addr == 3'd5 && lk[2],
                ok && req_addr == 3'd5 && !lk[2] && cfg_upd_mode && (flag_invalid || flag_overflow),
                ok && (req_addr < 3'd3 || req_addr == 3'd7),
                err};
    endfunction

    function automatic logic [3:0] exp_next(input logic [3:0] lk);
        logic err;
        err = req_valid && !req_priv && !cfg_user_ok;
        if (soft_rst) return 4'b1111;
        if (req_valid && !err && req_addr == 3'd6 && lk[3]) return lk & req_data[6:3];
        return lk;
    endfunction

    function automatic string tag_of(input logic [3:0] lk);
        if (soft_rst) return "R9";
        if (req_valid && !req_priv && !cfg_user_ok) return "R2";
        if (!req_valid) return "R4";
        if (req_addr == 3'd6) return lk[3] ? "R6" : "R7";
        if (req_addr == 3'd5 && !lk[2]) return "R8";
        if ((req_addr == 3'd3 && !lk[0]) || (req_addr == 3'd4 && !lk[1])) return "R5";
        if (!req_priv) return "R3";
        return "R4";
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // Drives at negedge (already there), checks outputs, advances model at posedge.
    task automatic step();
        logic [3:0] nxt;
        #2;
        check("lock_state", {4'b0, lock_state}, {4'b0, mdl_lk});
        check(tag_of(mdl_lk),
              {2'b0, we_comp, we_ctrl, we_stat, we_stat_tce, we_open, bus_err},
              {2'b0, exp_out(mdl_lk)});
        nxt = exp_next(mdl_lk);
        @(posedge clk);
        mdl_lk = nxt;
        @(negedge clk);
    endtask

    task automatic drive(input logic v, input logic [2:0] a, input logic [31:0] d,
                         input logic p, input logic uok, input logic upd,
                         input logic inv, input logic ovf, input logic sr);
        req_valid = v; req_addr = a; req_data = d; req_priv = p;
        cfg_user_ok = uok; cfg_upd_mode = upd; flag_invalid = inv;
        flag_overflow = ovf; soft_rst = sr;
        step();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        mdl_lk = 4'b1111;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1", {4'b0, lock_state}, 8'h0F);

        // directed
        drive(1, 3'd4, 32'h0, 1, 0, 0, 0, 0, 0);          // R4 ctrl unlocked
        drive(1, 3'd4, 32'h0, 0, 0, 0, 0, 0, 0);          // R2 error
        drive(1, 3'd6, 32'h0, 0, 0, 0, 0, 0, 0);          // R2 lock write refused
        drive(1, 3'd2, 32'h0, 0, 1, 0, 0, 0, 0);          // R3 unprivileged allowed
        drive(1, 3'd6, 32'hFFFF_FFEF, 1, 0, 0, 0, 0, 0);  // R6 lock ctrl
        drive(1, 3'd4, 32'h0, 1, 0, 0, 0, 0, 0);          // R5 ignored
        drive(1, 3'd6, 32'hFFFF_FFFF, 1, 0, 0, 0, 0, 0);  // R6 cannot re-set
        drive(1, 3'd6, 32'hFFFF_FFDF, 1, 0, 0, 0, 0, 0);  // lock status
        drive(1, 3'd5, 32'h0, 1, 0, 1, 1, 0, 0);          // R8 tce path
        drive(1, 3'd5, 32'h0, 1, 0, 1, 0, 0, 0);          // R8 no flag
        drive(1, 3'd5, 32'h0, 1, 0, 0, 0, 1, 0);          // R8 no update mode
        drive(1, 3'd6, 32'hFFFF_FFB7, 1, 0, 0, 0, 0, 0);  // R7 seal + lock comp
        drive(1, 3'd6, 32'h0, 1, 0, 0, 0, 0, 0);          // R7 ignored
        drive(1, 3'd3, 32'h0, 1, 0, 0, 0, 0, 0);          // R5 comp locked
        drive(1, 3'd6, 32'h0, 1, 0, 0, 0, 0, 1);          // R9 soft wins
        drive(0, 3'd0, 32'h0, 1, 0, 0, 0, 0, 0);          // R9 check reopen
        check("R9", {4'b0, lock_state}, 8'h0F);

        // constrained random
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] d;
            logic [2:0]  a;
            a = ($urandom % 4 != 0) ? 3'(3 + $urandom % 4) : 3'($urandom % 8);
            d = ($urandom % 4 == 0) ? $urandom : ~(32'h1 << (3 + $urandom % 4));
            drive($urandom % 8 != 0, a, d, $urandom % 10 < 7, $urandom % 2,
                  $urandom % 2, $urandom % 3 == 0, $urandom % 3 == 0,
                  $urandom % 40 == 0);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule